// File: doc/BRIEF.md
# Segment Selection and Linear Address Unit

This unit turns an effective offset into a linear address. It holds six segment registers. Each register keeps a 16-bit selector and a cached base and limit. For every memory access the unit works out which segment applies. It honours an explicit segment override, then adds that segment's base to the offset. With paging off, the linear address also serves as the physical address.

In legacy operation the unit checks the last byte of each access against the cached limit. A violation suppresses the access and raises a protection fault. In 64-bit operation four segments (code, data, stack and string destination) act as if their base were zero, and limit checks are skipped for every segment. Descriptor contents are supplied already resolved on a load port. Software loads aimed at the code segment are trapped. The code segment changes only through a separate control-transfer load strobe. A combinational readback port exposes any register's contents.

Segment codes used on every segment-valued port: 0 code (CS), 1 data (DS), 2 stack (SS), 3 string destination (ES), 4 extra F (FS), 5 extra G (GS). Codes 6 and 7 are unused. Access kinds on `accKind`: 0 instruction fetch, 1 plain data, 2 stack push/pop, 3 string destination.

Top module: `segAddrUnit`

## Requirements
- R1: A synchronous active-low reset clears every selector and base to zero and sets every limit to 0xFFFF. It also drives `linValid`, `gpFault` and `illegalFault` low.
- R2: A fetch access (kind 0) always uses segment 0, and the offset it uses is `ip` rather than `offset`. Any override is disregarded.
- R3: A non-fetch access with no usable override is assigned a default segment. A string destination (kind 3) uses segment 3. Otherwise, a stack access (kind 2), or an access whose `baseRegId` is 4 (stack pointer) or 5 (frame pointer), uses segment 2. All other accesses use segment 1. The segment chosen appears on `segUsed` one cycle after the request.
- R4: For non-fetch accesses, `ovrValid` with `ovrSeg` in 0..5 selects that segment ahead of every default rule. Override codes 6 and 7 are ignored.
- R5: One cycle after an accepted request, `linValid` is high and `linAddr` equals segment base plus offset, modulo 2^64.
- R6: Outside 64-bit mode, if offset + `accSize` - 1 (with `accSize` from 1 to 8 bytes) is greater than the selected limit, then one cycle later `gpFault` is high and `linValid` is low.
- R7: In 64-bit mode, segments 0 to 3 contribute a zero base. Segments 4 and 5 still add their cached base.
- R8: In 64-bit mode no access raises `gpFault`, whatever the limit.
- R9: A software load (`swLdValid`) aimed at segment 0 leaves that register unchanged and raises `illegalFault` for one cycle on the next edge. A software load to segment 1..5 writes selector, base and limit at the next edge. A software load to code 6 or 7 is dropped.
- R10: `xferLdValid` writes the load data into segment 0. When it is high, any software load in the same cycle is discarded and raises no fault.
- R11: The readback outputs and any access in the same cycle as a load still see the register's old contents. The new contents appear from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode64 | input | 1 | 64-bit operation when high |
| accReq | input | 1 | Access request this cycle |
| accKind | input | 2 | Access kind code |
| baseRegId | input | 4 | Base register index of the address expression |
| ovrValid | input | 1 | Segment override present |
| ovrSeg | input | 3 | Override segment code |
| offset | input | 64 | Effective offset for data accesses |
| ip | input | 64 | Instruction pointer for fetches |
| accSize | input | 4 | Access width in bytes |
| swLdValid | input | 1 | Software segment-register load |
| swLdSeg | input | 3 | Target segment of the software load |
| xferLdValid | input | 1 | Control-transfer load of the code segment |
| ldSelector | input | 16 | Selector to load |
| ldBase | input | 64 | Resolved base to load |
| ldLimit | input | 32 | Resolved limit to load |
| rdSeg | input | 3 | Segment chosen for readback |
| rdSelector | output | 16 | Selector of `rdSeg` (zero for codes 6, 7) |
| rdBase | output | 64 | Cached base of `rdSeg` |
| rdLimit | output | 32 | Cached limit of `rdSeg` |
| linValid | output | 1 | Registered: access accepted |
| linAddr | output | 64 | Registered linear (and physical) address |
| segUsed | output | 3 | Registered segment code used by the access |
| gpFault | output | 1 | Registered limit-violation fault |
| illegalFault | output | 1 | Registered trap for a software code-segment load |

## Verification
The address path is exercised with fetches, and with data accesses through stack-pointer, frame-pointer and plain base registers. It is also exercised with stack and string-destination kinds, with valid and out-of-range overrides, and in both operating modes. This separates the selection rules from one another and shows which bases are forced to zero. Limit checks use offsets that end exactly on the limit, one byte past it, and inside it with wider access sizes, so that off-by-one errors in the end-address test are exposed. Loads target the code segment by both paths, collide with accesses and readback in the same cycle, and use unused codes. A long randomized run, covering overflowing 64-bit offsets and small limits, is then compared each cycle against a behavioural model.

// File: rtl/segPkg.sv
package segPkg;

  localparam int NUM_SEG = 6;

  localparam logic [2:0] SEG_CS = 3'd0;
  localparam logic [2:0] SEG_DS = 3'd1;
  localparam logic [2:0] SEG_SS = 3'd2;
  localparam logic [2:0] SEG_ES = 3'd3;
  localparam logic [2:0] SEG_FS = 3'd4;
  localparam logic [2:0] SEG_GS = 3'd5;

  localparam logic [1:0] ACC_FETCH  = 2'd0;
  localparam logic [1:0] ACC_DATA   = 2'd1;
  localparam logic [1:0] ACC_STACK  = 2'd2;
  localparam logic [1:0] ACC_STRDST = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic       accGo;
    logic [2:0] seg;
    logic       useIp;
    logic       zeroBase;
    logic       chkLimit;
    logic       wrEn;
    logic [2:0] wrSeg;
  } segStrobes_t;

endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segPkg::*;
#(
  parameter int REG_ID_W = 4,
  parameter int SP_ID    = 4,
  parameter int BP_ID    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode64,
  input  logic                accReq,
  input  logic [1:0]          accKind,
  input  logic [REG_ID_W-1:0] baseRegId,
  input  logic                ovrValid,
  input  logic [2:0]          ovrSeg,
  input  logic                swLdValid,
  input  logic [2:0]          swLdSeg,
  input  logic                xferLdValid,
  output segStrobes_t         st,
  output logic                illegalFault
);

  localparam logic [REG_ID_W-1:0] SP_CODE = REG_ID_W'(SP_ID);
  localparam logic [REG_ID_W-1:0] BP_CODE = REG_ID_W'(BP_ID);
  localparam logic [2:0]          SEG_LIM = 3'(NUM_SEG);

  logic [2:0] defSeg;
  logic [2:0] selSeg;
  logic       stackBased;
  logic       ovrUsable;
  logic       csTrap;

  assign stackBased = (accKind == ACC_STACK) || (baseRegId == SP_CODE) || (baseRegId == BP_CODE);
  assign ovrUsable  = ovrValid && (ovrSeg < SEG_LIM);

  always_comb begin
    if (accKind == ACC_STRDST)  defSeg = SEG_ES;
    else if (stackBased)        defSeg = SEG_SS;
    else                        defSeg = SEG_DS;
  end

  always_comb begin
    if (accKind == ACC_FETCH)   selSeg = SEG_CS;
    else if (ovrUsable)         selSeg = ovrSeg;
    else                        selSeg = defSeg;
  end

  assign csTrap = swLdValid && !xferLdValid && (swLdSeg == SEG_CS);

  always_comb begin
    st          = '0;
    st.accGo    = accReq;
    st.seg      = selSeg;
    st.useIp    = (accKind == ACC_FETCH);
    st.zeroBase = mode64 && (selSeg != SEG_FS) && (selSeg != SEG_GS);
    st.chkLimit = accReq && !mode64;
    if (xferLdValid) begin
      st.wrEn  = 1'b1;
      st.wrSeg = SEG_CS;
    end else if (swLdValid && (swLdSeg != SEG_CS) && (swLdSeg < SEG_LIM)) begin
      st.wrEn  = 1'b1;
      st.wrSeg = swLdSeg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) illegalFault <= 1'b0;
    else        illegalFault <= csTrap;
  end

  AST_CS_LOAD_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (swLdValid && !xferLdValid && swLdSeg == SEG_CS) |=> illegalFault); // R9
  AST_SEG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    accReq |-> (st.seg < SEG_LIM)); // R3
  AST_SW_NEVER_WRITES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (st.wrEn && st.wrSeg == SEG_CS) |-> xferLdValid); // R9

endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segPkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LIM_W  = 32,
  parameter int SEL_W  = 16,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  segStrobes_t       st,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] ip,
  input  logic [SIZE_W-1:0] accSize,
  input  logic [SEL_W-1:0]  ldSelector,
  input  logic [ADDR_W-1:0] ldBase,
  input  logic [LIM_W-1:0]  ldLimit,
  input  logic [2:0]        rdSeg,
  output logic [SEL_W-1:0]  rdSelector,
  output logic [ADDR_W-1:0] rdBase,
  output logic [LIM_W-1:0]  rdLimit,
  output logic              linValid,
  output logic [ADDR_W-1:0] linAddr,
  output logic [2:0]        segUsed,
  output logic              gpFault
);

  localparam logic [LIM_W-1:0] RST_LIM = LIM_W'(16'hFFFF);
  localparam int               EXT_W   = ADDR_W + 1;
  localparam logic [2:0]       SEG_LIM = 3'(NUM_SEG);

  logic [SEL_W-1:0]  selR  [NUM_SEG];
  logic [ADDR_W-1:0] baseR [NUM_SEG];
  logic [LIM_W-1:0]  limR  [NUM_SEG];

  logic [ADDR_W-1:0] effOff;
  logic [ADDR_W-1:0] baseV;
  logic [EXT_W-1:0]  endAddr;
  logic [NUM_SEG-1:0] overVec;
  logic              overLimit;
  logic              faultNow;

  // register file
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SEG; i++) begin
      if (!rst_n) begin
        selR[i]  <= '0;
        baseR[i] <= '0;
        limR[i]  <= RST_LIM;
      end else if (st.wrEn && (st.wrSeg == 3'(i))) begin
        selR[i]  <= ldSelector;
        baseR[i] <= ldBase;
        limR[i]  <= ldLimit;
      end
    end
  end

  // readback
  always_comb begin
    rdSelector = '0;
    rdBase     = '0;
    rdLimit    = '0;
    if (rdSeg < SEG_LIM) begin
      rdSelector = selR[rdSeg];
      rdBase     = baseR[rdSeg];
      rdLimit    = limR[rdSeg];
    end
  end

  assign effOff  = st.useIp ? ip : offset;
  assign baseV   = st.zeroBase ? '0 : baseR[st.seg];
  assign endAddr = {1'b0, effOff} + EXT_W'(accSize) - EXT_W'(1);

  // per-segment limit comparators
  for (genvar g = 0; g < NUM_SEG; g++) begin : gLimCmp
    assign overVec[g] = endAddr > EXT_W'(limR[g]);
  end

  assign overLimit = overVec[st.seg];
  assign faultNow  = st.chkLimit && overLimit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      linValid <= 1'b0;
      gpFault  <= 1'b0;
      linAddr  <= '0;
      segUsed  <= '0;
    end else begin
      linValid <= st.accGo && !faultNow;
      gpFault  <= faultNow;
      linAddr  <= baseV + effOff;
      segUsed  <= st.seg;
    end
  end

  AST_FAULT_SUPPRESSES: assert property (@(posedge clk) disable iff (!rst_n)
    gpFault |-> !linValid); // R6
  AST_NO_FAULT_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
    !st.chkLimit |=> !gpFault); // R8
  AST_FLAT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st.accGo && st.zeroBase) |=> (linAddr == $past(effOff))); // R7
  AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(st.wrEn && st.wrSeg == SEG_CS) |=> ($stable(selR[0]) && $stable(baseR[0]))); // R9

endmodule

// File: rtl/segAddrUnit.sv
module segAddrUnit
  import segPkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int LIM_W    = 32,
  parameter int SEL_W    = 16,
  parameter int SIZE_W   = 4,
  parameter int REG_ID_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode64,
  input  logic                accReq,
  input  logic [1:0]          accKind,
  input  logic [REG_ID_W-1:0] baseRegId,
  input  logic                ovrValid,
  input  logic [2:0]          ovrSeg,
  input  logic [ADDR_W-1:0]   offset,
  input  logic [ADDR_W-1:0]   ip,
  input  logic [SIZE_W-1:0]   accSize,
  input  logic                swLdValid,
  input  logic [2:0]          swLdSeg,
  input  logic                xferLdValid,
  input  logic [SEL_W-1:0]    ldSelector,
  input  logic [ADDR_W-1:0]   ldBase,
  input  logic [LIM_W-1:0]    ldLimit,
  input  logic [2:0]          rdSeg,
  output logic [SEL_W-1:0]    rdSelector,
  output logic [ADDR_W-1:0]   rdBase,
  output logic [LIM_W-1:0]    rdLimit,
  output logic                linValid,
  output logic [ADDR_W-1:0]   linAddr,
  output logic [2:0]          segUsed,
  output logic                gpFault,
  output logic                illegalFault
);

  segStrobes_t st;

  segCtrl #(
    .REG_ID_W (REG_ID_W),
    .SP_ID    (4),
    .BP_ID    (5)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode64       (mode64),
    .accReq       (accReq),
    .accKind      (accKind),
    .baseRegId    (baseRegId),
    .ovrValid     (ovrValid),
    .ovrSeg       (ovrSeg),
    .swLdValid    (swLdValid),
    .swLdSeg      (swLdSeg),
    .xferLdValid  (xferLdValid),
    .st           (st),
    .illegalFault (illegalFault)
  );

  segDatapath #(
    .ADDR_W (ADDR_W),
    .LIM_W  (LIM_W),
    .SEL_W  (SEL_W),
    .SIZE_W (SIZE_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .offset     (offset),
    .ip         (ip),
    .accSize    (accSize),
    .ldSelector (ldSelector),
    .ldBase     (ldBase),
    .ldLimit    (ldLimit),
    .rdSeg      (rdSeg),
    .rdSelector (rdSelector),
    .rdBase     (rdBase),
    .rdLimit    (rdLimit),
    .linValid   (linValid),
    .linAddr    (linAddr),
    .segUsed    (segUsed),
    .gpFault    (gpFault)
  );

endmodule

// File: tb/segAddrUnit_bench.sv
module segAddrUnit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode64;
  logic        accReq;
  logic [1:0]  accKind;
  logic [3:0]  baseRegId;
  logic        ovrValid;
  logic [2:0]  ovrSeg;
  logic [63:0] offset;
  logic [63:0] ip;
  logic [3:0]  accSize;
  logic        swLdValid;
  logic [2:0]  swLdSeg;
  logic        xferLdValid;
  logic [15:0] ldSelector;
  logic [63:0] ldBase;
  logic [31:0] ldLimit;
  logic [2:0]  rdSeg;
  logic [15:0] rdSelector;
  logic [63:0] rdBase;
  logic [31:0] rdLimit;
  logic        linValid;
  logic [63:0] linAddr;
  logic [2:0]  segUsed;
  logic        gpFault;
  logic        illegalFault;

  always #4 clk = ~clk; // 125 MHz

  segAddrUnit u_segAddrUnit (
    .clk(clk), .rst_n(rst_n), .mode64(mode64), .accReq(accReq), .accKind(accKind),
    .baseRegId(baseRegId), .ovrValid(ovrValid), .ovrSeg(ovrSeg), .offset(offset),
    .ip(ip), .accSize(accSize), .swLdValid(swLdValid), .swLdSeg(swLdSeg),
    .xferLdValid(xferLdValid), .ldSelector(ldSelector), .ldBase(ldBase),
    .ldLimit(ldLimit), .rdSeg(rdSeg), .rdSelector(rdSelector), .rdBase(rdBase),
    .rdLimit(rdLimit), .linValid(linValid), .linAddr(linAddr), .segUsed(segUsed),
    .gpFault(gpFault), .illegalFault(illegalFault)
  );

  // reference model state
  logic [15:0] mSel  [6];
  logic [63:0] mBase [6];
  logic [31:0] mLim  [6];

  int  nChecks = 0;
  int  nErr    = 0;
  bit  done    = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    accReq = 0; accKind = 2'd1; baseRegId = 4'd0; ovrValid = 0; ovrSeg = 3'd0;
    offset = '0; ip = '0; accSize = 4'd1; swLdValid = 0; swLdSeg = 3'd0;
    xferLdValid = 0; ldSelector = '0; ldBase = '0; ldLimit = '0;
  endtask

  task automatic acc(logic [1:0] k, logic [3:0] br, logic ov, logic [2:0] os,
                     logic [63:0] off, logic [3:0] sz, logic m64);
    accReq = 1; accKind = k; baseRegId = br; ovrValid = ov; ovrSeg = os;
    offset = off; ip = off; accSize = sz; mode64 = m64;
  endtask

  task automatic ld(logic sw, logic [2:0] sg, logic xf, logic [15:0] sl,
                    logic [63:0] bs, logic [31:0] lm);
    swLdValid = sw; swLdSeg = sg; xferLdValid = xf;
    ldSelector = sl; ldBase = bs; ldLimit = lm;
  endtask

  // one clock: check readback, predict, advance, compare registered outputs
  task automatic step();
    logic [2:0]  s;
    logic [63:0] o;
    logic [64:0] e;
    logic        flt, eValid, eFault, eIll;
    logic [63:0] eAddr;
    string       tSeg, tAddr, tFlt;
    #1;
    if (rdSeg < 3'd6) begin
      chk("R11 readback selector", 64'(rdSelector), 64'(mSel[rdSeg]));
      chk("R11 readback base", rdBase, mBase[rdSeg]);
      chk("R11 readback limit", 64'(rdLimit), 64'(mLim[rdSeg]));
    end else begin
      chk("R11 readback unused code", 64'(rdSelector), 64'd0);
    end
    // segment choice
    if (accKind == 2'd0) begin s = 3'd0; tSeg = "R2"; end
    else if (ovrValid && ovrSeg < 3'd6) begin s = ovrSeg; tSeg = "R4"; end
    else if (accKind == 2'd3) begin s = 3'd3; tSeg = "R3"; end
    else if (accKind == 2'd2 || baseRegId == 4'd4 || baseRegId == 4'd5) begin s = 3'd2; tSeg = "R3"; end
    else begin s = 3'd1; tSeg = (ovrValid ? "R4" : "R3"); end
    o = (accKind == 2'd0) ? ip : offset;
    e = {1'b0, o} + 65'(accSize) - 65'd1;
    flt    = !mode64 && (e > {33'd0, mLim[s]});
    eValid = accReq && !flt;
    eFault = accReq && flt;
    eAddr  = ((mode64 && s < 3'd4) ? 64'd0 : mBase[s]) + o;
    eIll   = swLdValid && !xferLdValid && swLdSeg == 3'd0;
    tAddr  = mode64 ? "R7" : "R5";
    tFlt   = mode64 ? "R8" : "R6";
    // model writes
    if (xferLdValid) begin
      mSel[0] = ldSelector; mBase[0] = ldBase; mLim[0] = ldLimit;
    end else if (swLdValid && swLdSeg >= 3'd1 && swLdSeg <= 3'd5) begin
      mSel[swLdSeg] = ldSelector; mBase[swLdSeg] = ldBase; mLim[swLdSeg] = ldLimit;
    end
    @(posedge clk);
    @(negedge clk);
    chk({tFlt, " linValid"}, 64'(linValid), 64'(eValid));
    chk({tFlt, " gpFault"}, 64'(gpFault), 64'(eFault));
    if (eValid) chk({tAddr, " linAddr"}, linAddr, eAddr);
    if (accReq) chk({tSeg, " segUsed"}, 64'(segUsed), 64'(s));
    chk("R9 illegalFault", 64'(illegalFault), 64'(eIll));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin mSel[i] = '0; mBase[i] = '0; mLim[i] = 32'hFFFF; end
    idle(); mode64 = 0; rdSeg = 3'd0; rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 linValid", 64'(linValid), 64'd0);
    chk("R1 gpFault", 64'(gpFault), 64'd0);
    chk("R1 illegalFault", 64'(illegalFault), 64'd0);
    for (int i = 0; i < 6; i++) begin
      rdSeg = 3'(i); #1;
      chk("R1 selector", 64'(rdSelector), 64'd0);
      chk("R1 base", rdBase, 64'd0);
      chk("R1 limit", 64'(rdLimit), 64'hFFFF);
    end
    rst_n = 1;
    @(negedge clk);

    // loads
    idle(); rdSeg = 3'd1;
    ld(1, 3'd1, 0, 16'h0023, 64'h1000, 32'h00FF); step();
    ld(1, 3'd2, 0, 16'h0030, 64'h2000, 32'hFFFF); step();
    ld(1, 3'd3, 0, 16'h0038, 64'h3000, 32'h0FFF); step();
    ld(1, 3'd4, 0, 16'h0040, 64'h7000_0000, 32'h0FFF); step();
    ld(1, 3'd5, 0, 16'h0048, 64'h9_0000_0000, 32'hFFFF); step();
    rdSeg = 3'd0;
    ld(1, 3'd0, 0, 16'h0099, 64'hDEAD, 32'h1); step();
    #1 chk("R9 CS base unchanged", rdBase, 64'd0);
    chk("R9 CS selector unchanged", 64'(rdSelector), 64'd0);
    ld(0, 3'd0, 1, 16'h0008, 64'h40000, 32'hFFFF); step();
    #1 chk("R10 CS base from transfer", rdBase, 64'h40000);
    rdSeg = 3'd1;
    ld(1, 3'd1, 1, 16'h0010, 64'h50000, 32'hFFFF); step();
    #1 chk("R10 DS untouched by discarded load", rdBase, 64'h1000);
    chk("R10 no trap on discarded load", 64'(illegalFault), 64'd0);
    ld(1, 3'd6, 0, 16'h0077, 64'h7777, 32'h7); step();
    idle();

    // selection
    acc(2'd0, 4'd0, 1, 3'd4, 64'h10, 4'd1, 0); step();   // R2 fetch ignores override
    acc(2'd1, 4'd4, 0, 3'd0, 64'h20, 4'd4, 0); step();   // R3 SP base
    acc(2'd1, 4'd5, 0, 3'd0, 64'h20, 4'd4, 0); step();   // R3 BP base
    acc(2'd2, 4'd0, 0, 3'd0, 64'h20, 4'd8, 0); step();   // R3 stack
    acc(2'd3, 4'd4, 0, 3'd0, 64'h20, 4'd1, 0); step();   // R3 string dest
    acc(2'd1, 4'd1, 0, 3'd0, 64'h20, 4'd1, 0); step();   // R3 data
    acc(2'd1, 4'd4, 1, 3'd5, 64'h20, 4'd1, 0); step();   // R4 override beats SP
    acc(2'd1, 4'd4, 1, 3'd7, 64'h20, 4'd1, 0); step();   // R4 code 7 ignored
    // limit boundary on DS (limit 0xFF)
    acc(2'd1, 4'd0, 0, 3'd0, 64'hFF, 4'd1, 0); step();   // R6 exactly on limit
    acc(2'd1, 4'd0, 0, 3'd0, 64'hFF, 4'd2, 0); step();   // R6 one past
    acc(2'd1, 4'd0, 0, 3'd0, 64'hFC, 4'd4, 0); step();   // R6 inside
    acc(2'd1, 4'd0, 0, 3'd0, 64'hFD, 4'd4, 0); step();   // R6 over
    // 64-bit mode
    acc(2'd1, 4'd0, 0, 3'd0, 64'hFFFF_0000_1234, 4'd8, 1); step(); // R7 R8 DS flat
    acc(2'd1, 4'd0, 1, 3'd4, 64'h1_0000, 4'd8, 1); step();         // R7 FS base kept
    acc(2'd1, 4'd0, 1, 3'd5, 64'hFFFF_FFF8_0000_0000, 4'd8, 1); step(); // R7 GS wrap
    acc(2'd0, 4'd0, 0, 3'd0, 64'h8000_0000_0000, 4'd1, 1); step(); // R7 CS flat
    // R11 access and load collide on DS
    acc(2'd1, 4'd0, 0, 3'd0, 64'h80, 4'd1, 0);
    ld(1, 3'd1, 0, 16'h0050, 64'hA000, 32'h7F); step();
    ld(0, 3'd0, 0, 16'h0, 64'h0, 32'h0); step();
    idle(); mode64 = 0;

    // randomized
    for (int n = 0; n < 3000; n++) begin
      accReq    = ($urandom % 4) != 0;
      accKind   = 2'($urandom);
      baseRegId = 4'($urandom % 8);
      ovrValid  = ($urandom % 4) == 0;
      ovrSeg    = 3'($urandom);
      offset    = ($urandom % 2) ? 64'($urandom % 1024) : {$urandom, $urandom};
      ip        = ($urandom % 2) ? 64'($urandom % 1024) : {$urandom, $urandom};
      accSize   = 4'(1 + $urandom % 8);
      mode64    = ($urandom % 3) == 0;
      swLdValid = ($urandom % 6) == 0;
      swLdSeg   = 3'($urandom);
      xferLdValid = ($urandom % 16) == 0;
      ldSelector = 16'($urandom);
      ldBase     = ($urandom % 2) ? 64'($urandom % 4096) : {$urandom, $urandom};
      ldLimit    = ($urandom % 2) ? ($urandom % 1024) : $urandom;
      rdSeg      = 3'($urandom);
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule